// File: doc/BRIEF.md
# Ethernet MAC Control Register File

This block is the software-visible control and status store of an Ethernet MAC. A host reads and writes 32-bit words through a simple word-indexed port; the byte offset of a register is its index times four. It holds the transmit and receive descriptor ring base addresses, a command word, an interrupt enable mask, a status word whose bits are cleared by writing ones, FIFO threshold, maximum receive size, missed-frame counter and management data/address words, and sixteen pairs of station address match words.

The DMA engines are outside the block. They raise status bits through a vector of one-cycle event pulses, and they consume the decoded controls: transmit on, receive on, long-frame acceptance, the match controls and both ring bases. The status word is split in two. Its upper half, gated by the enable mask, forms the transmit interrupt line, and its lower half forms the receive interrupt line.

Setting the reset bit of the command word starts a software reset. Every register returns to its reset value at once. For a fixed eight cycles afterwards, every read returns zero and every write or event is dropped.

Top module: `mac_ctrl_regs`

## Requirements
- R1: After the synchronous reset, the ring base registers read 0xFFFFFFFC, FIFO threshold reads 0x0101, maximum receive size reads 0x0800, missed-frame counter reads 0x7FFF, management data/address reads 0x00900000, and every other register, including all match words, reads 0. Word indices: command 0, enable 1, status 2, transmit ring 3, receive ring 4, FIFO threshold 5, maximum receive size 6, missed-frame counter 7, management 8, match control 9, match enable 10.
- R2: In the command word, bit 8 drives `tx_on`, bit 0 drives `rx_on` and bit 1 drives `long_ok`. In the match control word, bit 0 drives `ucast_all` and bit 4 drives `cmp_on`.
- R3: Writing the command word with bit 24 set resets all registers. A read issued in any of the following 8 cycles returns 0. After that, reads return the reset values, and bit 24 of the command word reads 0.
- R4: Writes and event pulses that arrive while the software reset is in progress change no register.
- R5: An event pulse on bit n sets status bit n. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: When an event sets a status bit in the same cycle that a write of 1 clears that bit, the bit ends up set.
- R7: `tx_irq` is high one cycle after any status bit in 31:16 is set together with its enable bit, and low once none is. Transmit complete is bit 18 and transmit interrupt is bit 16.
- R8: `rx_irq` does the same for status bits 15:0. Receive good is bit 4 and receive interrupt is bit 0.
- R9: Match word pair i is at index 16+2i (upper part) followed by 17+2i (lower part). Each word is readable and writable for i from 0 to 15.
- R10: Only status bits 24, 23, 18, 16, 11, 10, 9, 8, 4, 3 and 0 can be set by events. A pulse on any other bit leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word index |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| evt | input | 32 | Status set pulses from the DMA engines |
| tx_irq | output | 1 | Transmit interrupt line |
| rx_irq | output | 1 | Receive interrupt line |
| tx_on | output | 1 | Transmit enable |
| rx_on | output | 1 | Receive enable |
| long_ok | output | 1 | Accept frames above the maximum size |
| ucast_all | output | 1 | Accept every unicast frame |
| cmp_on | output | 1 | Address comparison enable |
| tx_ring | output | 32 | Transmit descriptor ring base |
| rx_ring | output | 32 | Receive descriptor ring base |

## Verification
An event pulse from a DMA engine and a host write of 1 to the same status bit can land on one clock edge. The bench drives both strobes for a single cycle on receive-good while also clearing another bit in the same write. It expects the colliding bit to survive and the other bit to clear. A second collision, a write or event arriving inside the software reset window, is provoked by issuing both right after the reset command. It is judged by reading the affected registers back once the window has closed.

// File: rtl/mac_regs_pkg.sv
package mac_regs_pkg;
  localparam int DW = 32;
  localparam int AW = 6;

  localparam logic [AW-1:0] IX_CMD   = 6'd0;
  localparam logic [AW-1:0] IX_IEN   = 6'd1;
  localparam logic [AW-1:0] IX_STS   = 6'd2;
  localparam logic [AW-1:0] IX_TXR   = 6'd3;
  localparam logic [AW-1:0] IX_RXR   = 6'd4;
  localparam logic [AW-1:0] IX_FTHR  = 6'd5;
  localparam logic [AW-1:0] IX_RMAX  = 6'd6;
  localparam logic [AW-1:0] IX_MISS  = 6'd7;
  localparam logic [AW-1:0] IX_MGMT  = 6'd8;
  localparam logic [AW-1:0] IX_MCTL  = 6'd9;
  localparam logic [AW-1:0] IX_MEN   = 6'd10;
  localparam int            MATCH_BASE = 16;

  localparam logic [DW-1:0] RV_RING = 32'hFFFF_FFFC;
  localparam logic [DW-1:0] RV_FTHR = 32'h0000_0101;
  localparam logic [DW-1:0] RV_RMAX = 32'h0000_0800;
  localparam logic [DW-1:0] RV_MISS = 32'h0000_7FFF;
  localparam logic [DW-1:0] RV_MGMT = 32'h0090_0000;

  localparam logic [DW-1:0] STS_DEFINED = 32'h0185_0F19;

  localparam int CMD_SRST = 24;
  localparam int CMD_TXON = 8;
  localparam int CMD_LONG = 1;
  localparam int CMD_RXON = 0;
  localparam int MCTL_UCAST = 0;
  localparam int MCTL_CMP   = 4;
endpackage

// File: rtl/srst_seq.sv
module srst_seq #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic clr
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);
  assign clr  = start && !busy;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= CW'(CYC);
    else if (busy) cnt <= cnt - CW'(1);
  end

  // R3
  cnt_down_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int DW = 32,
  parameter logic [DW-1:0] SET_MASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hold,
  input  logic [DW-1:0] w1c,
  input  logic [DW-1:0] evt,
  input  logic [DW-1:0] ien,
  output logic [DW-1:0] sts,
  output logic          tx_irq,
  output logic          rx_irq
);
  localparam int HW = DW / 2;
  logic [DW-1:0] set_v;
  logic [DW-1:0] act;

  assign set_v = hold ? '0 : (evt & SET_MASK);
  assign act   = sts & ien;

  always_ff @(posedge clk) begin
    if (rst || clr) sts <= '0;
    else            sts <= (sts & ~w1c) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      tx_irq <= |act[DW-1:HW];
      rx_irq <= |act[HW-1:0];
    end
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && set_v != '0) |=> ((sts & $past(set_v)) == $past(set_v)));
  // R7
  tx_line_chk: assert property (@(posedge clk) disable iff (rst)
    (act[DW-1:HW] != '0) |=> tx_irq);
  // R8
  rx_line_chk: assert property (@(posedge clk) disable iff (rst)
    (act[HW-1:0] == '0) |=> !rx_irq);
endmodule

// File: rtl/match_bank.sv
module match_bank #(
  parameter int DW    = 32,
  parameter int PAIRS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [$clog2(2*PAIRS)-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 2 * PAIRS;
  logic [DW-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || clr)                      mem[g] <= '0;
      else if (we && idx == g[$clog2(WORDS)-1:0]) mem[g] <= wdata;
    end
  end

  assign rdata = mem[idx];

  // R9
  match_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (mem[0] == '0 && mem[WORDS-1] == '0));
endmodule

// File: rtl/mac_ctrl_regs.sv
module mac_ctrl_regs
  import mac_regs_pkg::*;
#(
  parameter int PAIRS    = 16,
  parameter int SRST_CYC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] evt,
  output logic          tx_irq,
  output logic          rx_irq,
  output logic          tx_on,
  output logic          rx_on,
  output logic          long_ok,
  output logic          ucast_all,
  output logic          cmp_on,
  output logic [DW-1:0] tx_ring,
  output logic [DW-1:0] rx_ring
);
  localparam int LW = $clog2(2 * PAIRS);

  logic busy, clr, wr_ok, srst_req;
  logic [DW-1:0] cmd, ien, sts, fthr, rmax, miss, mgmt, mctl, men;
  logic [DW-1:0] m_rdata, rmux, w1c;
  logic [AW-1:0] moff;
  logic in_match;

  assign wr_ok    = wr_en && !busy;
  assign srst_req = wr_ok && addr == IX_CMD && wr_data[CMD_SRST];
  assign moff     = addr - AW'(MATCH_BASE);
  assign in_match = (addr >= AW'(MATCH_BASE)) && (moff < AW'(2 * PAIRS));
  assign w1c      = (wr_ok && addr == IX_STS) ? wr_data : '0;

  srst_seq #(.CYC(SRST_CYC)) u_srst (
    .clk(clk), .rst(rst), .start(srst_req), .busy(busy), .clr(clr)
  );

  irq_status #(.DW(DW), .SET_MASK(STS_DEFINED)) u_sts (
    .clk(clk), .rst(rst), .clr(clr), .hold(busy), .w1c(w1c), .evt(evt),
    .ien(ien), .sts(sts), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  match_bank #(.DW(DW), .PAIRS(PAIRS)) u_match (
    .clk(clk), .rst(rst), .clr(clr), .we(wr_ok && in_match),
    .idx(moff[LW-1:0]), .wdata(wr_data), .rdata(m_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cmd     <= '0;
      ien     <= '0;
      tx_ring <= RV_RING;
      rx_ring <= RV_RING;
      fthr    <= RV_FTHR;
      rmax    <= RV_RMAX;
      miss    <= RV_MISS;
      mgmt    <= RV_MGMT;
      mctl    <= '0;
      men     <= '0;
    end else if (wr_ok) begin
      case (addr)
        IX_CMD:  cmd     <= wr_data & ~(DW'(1) << CMD_SRST);
        IX_IEN:  ien     <= wr_data;
        IX_TXR:  tx_ring <= wr_data;
        IX_RXR:  rx_ring <= wr_data;
        IX_FTHR: fthr    <= wr_data;
        IX_RMAX: rmax    <= wr_data;
        IX_MISS: miss    <= wr_data;
        IX_MGMT: mgmt    <= wr_data;
        IX_MCTL: mctl    <= wr_data;
        IX_MEN:  men     <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    rmux = '0;
    if (in_match) rmux = m_rdata;
    else begin
      case (addr)
        IX_CMD:  rmux = cmd;
        IX_IEN:  rmux = ien;
        IX_STS:  rmux = sts;
        IX_TXR:  rmux = tx_ring;
        IX_RXR:  rmux = rx_ring;
        IX_FTHR: rmux = fthr;
        IX_RMAX: rmux = rmax;
        IX_MISS: rmux = miss;
        IX_MGMT: rmux = mgmt;
        IX_MCTL: rmux = mctl;
        IX_MEN:  rmux = men;
        default: rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_en)  rd_data <= busy ? '0 : rmux;
  end

  assign tx_on     = cmd[CMD_TXON];
  assign rx_on     = cmd[CMD_RXON];
  assign long_ok   = cmd[CMD_LONG];
  assign ucast_all = mctl[MCTL_UCAST];
  assign cmp_on    = mctl[MCTL_CMP];

  // R3
  busy_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (rd_data == '0));
  // R4
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> (tx_ring == $past(tx_ring) && ien == $past(ien)));
  // R3
  srst_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cmd == '0));
endmodule

// File: tb/mac_ctrl_regs_tb_top.sv
module mac_ctrl_regs_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wr_data = '0, evt = '0, rd_data;
  logic tx_irq, rx_irq, tx_on, rx_on, long_ok, ucast_all, cmp_on;
  logic [31:0] tx_ring, rx_ring;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  mac_ctrl_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .evt(evt), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .tx_on(tx_on), .rx_on(rx_on), .long_ok(long_ok),
    .ucast_all(ucast_all), .cmp_on(cmp_on), .tx_ring(tx_ring),
    .rx_ring(rx_ring)
  );

  // {index, write value, expected read}
  localparam logic [69:0] VEC [0:12] = '{
    {6'd3,  32'h1234_5678, 32'h1234_5678},
    {6'd4,  32'hA5A5_A5A4, 32'hA5A5_A5A4},
    {6'd1,  32'h0005_0011, 32'h0005_0011},
    {6'd5,  32'h0000_0003, 32'h0000_0003},
    {6'd6,  32'h0000_05EE, 32'h0000_05EE},
    {6'd7,  32'h0000_0010, 32'h0000_0010},
    {6'd8,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {6'd9,  32'h0000_0011, 32'h0000_0011},
    {6'd10, 32'h0000_FFFF, 32'h0000_FFFF},
    {6'd16, 32'hCAFE_0001, 32'hCAFE_0001},
    {6'd47, 32'h0BAD_F00D, 32'h0BAD_F00D},
    {6'd0,  32'h0000_0103, 32'h0000_0103},
    {6'd2,  32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1 v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic rchk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    rchk("R1 txring", 6'd3, 32'hFFFF_FFFC);
    rchk("R1 rxring", 6'd4, 32'hFFFF_FFFC);
    rchk("R1 fthr",   6'd5, 32'h0000_0101);
    rchk("R1 rmax",   6'd6, 32'h0000_0800);
    rchk("R1 miss",   6'd7, 32'h0000_7FFF);
    rchk("R1 mgmt",   6'd8, 32'h0090_0000);
    rchk("R1 cmd",    6'd0, 32'h0);
    rchk("R1 sts",    6'd2, 32'h0);
    rchk("R1 match",  6'd33, 32'h0);
    chk("R1 irq", {30'd0, tx_irq, rx_irq}, 32'h0);

    // R9 R5 table walk
    for (int i = 0; i < 13; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rchk("R9 R5 table", VEC[i][69:64], VEC[i][31:0]);
    end
    // R2 decoded controls (cmd 0x103, match ctl 0x11)
    chk("R2 cmd bits", {29'd0, tx_on, long_ok, rx_on}, 32'h7);
    chk("R2 match bits", {30'd0, ucast_all, cmp_on}, 32'h3);
    chk("R2 rings", tx_ring, 32'h1234_5678);

    // R3 R4 soft reset
    wr(6'd0, 32'h0100_0000);
    wr(6'd3, 32'h5555_5554);
    rchk("R3 busy read", 6'd5, 32'h0);
    pulse(32'h0000_0010);
    repeat (10) @(negedge clk);
    rchk("R4 write dropped", 6'd3, 32'hFFFF_FFFC);
    rchk("R4 event dropped", 6'd2, 32'h0);
    rchk("R3 cmd after", 6'd0, 32'h0);
    rchk("R3 fthr after", 6'd5, 32'h0000_0101);
    rchk("R3 miss after", 6'd7, 32'h0000_7FFF);
    rchk("R3 match after", 6'd16, 32'h0);
    chk("R3 outputs", {30'd0, tx_on, ucast_all}, 32'h0);

    // R10 undefined bit
    pulse(32'h0000_0002);
    rchk("R10 undefined", 6'd2, 32'h0);

    // R5 set and clear
    pulse(32'h0001_0009);
    rchk("R5 set", 6'd2, 32'h0001_0009);
    wr(6'd2, 32'h0000_0001);
    rchk("R5 w1c", 6'd2, 32'h0001_0008);

    // R6 collision: event bit4 with W1C of bits 4 and 3
    @(negedge clk); wr_en = 1'b1; addr = 6'd2; wr_data = 32'h0000_0018; evt = 32'h0000_0010;
    @(negedge clk); wr_en = 1'b0; evt = '0;
    rchk("R6 set wins", 6'd2, 32'h0001_0010);
    wr(6'd2, 32'hFFFF_FFFF);

    // R7 transmit line
    wr(6'd1, 32'h0004_0000);
    pulse(32'h0001_0000);
    @(posedge clk); #1 chk("R7 masked", {31'd0, tx_irq}, 32'h0);
    pulse(32'h0004_0000);
    @(posedge clk); #1 chk("R7 tx high", {30'd0, tx_irq, rx_irq}, 32'h2);
    wr(6'd2, 32'h0005_0000);
    @(posedge clk); #1 chk("R7 tx low", {31'd0, tx_irq}, 32'h0);

    // R8 receive line
    wr(6'd1, 32'h0000_0010);
    pulse(32'h0000_0100);
    @(posedge clk); #1 chk("R8 masked", {31'd0, rx_irq}, 32'h0);
    pulse(32'h0000_0010);
    @(posedge clk); #1 chk("R8 rx high", {30'd0, tx_irq, rx_irq}, 32'h1);
    wr(6'd2, 32'h0000_0010);
    @(posedge clk); #1 chk("R8 rx low", {31'd0, rx_irq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule